// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block turns a 32.768 kHz clock-enable into a one-cycle seconds tick for a calendar. Its divider chain normally counts 32768 enables per second. It can also apply a digital rate trim. Over a repeating cycle of 64 minutes, the first second of some minutes is made shorter (to speed the clock up) or longer (to slow it down). A 5-bit magnitude in the control byte sets how many minutes get this correction.

The same control byte also sets what the open-drain output pin does. In test mode the pin shows a square wave at 512 Hz, taken from a counter that the trim never touches. Otherwise the pin holds a static level. A stop input from the calendar keeps the divider cleared, so no ticks come out while it is high.

The divider is a state machine with three states:
- `DV_RUN`: counting.
- `DV_STRETCH`: adding the extra half-stage at the end of a slowed second.
- `DV_HOLD`: forced while stop is high.

Its transitions:
- RUN→RUN: a normal or shortened second ends.
- RUN→STRETCH: a slowed second reaches its normal end.
- STRETCH→RUN: the stretch is used up.
- any→HOLD: stop is high.
- HOLD→RUN: the first cycle without stop.

Control byte layout: bits 4:0 hold the magnitude, bit 5 the sign (1 = faster), bit 6 the test-mode enable, bit 7 the static level.

Top module: `presc_top`

## Requirements
- R1: With no correction, a second lasts 2^(LO_W+HI_W) enables (32768 by default). `sec_tick` is high for one clock, in the cycle after the edge that samples the enable completing the second.
- R2: Only clock cycles with `osc_en` high advance the divider. Idle cycles between enables do not change the length of a second measured in enables.
- R3: A second is corrected only when it is second 0 of minute m and m < 2×magnitude, where the magnitude is `ctrl[4:0]`. A magnitude of 0 corrects nothing, and minutes 62 and 63 are never corrected.
- R4: With `ctrl[5]`=1 (positive), a corrected second is 2^LO_W enables shorter than normal (256 by default).
- R5: With `ctrl[5]`=0 (negative), a corrected second is 2^(LO_W-1) enables longer than normal (128 by default).
- R6: Each minute holds SEC_PER_MIN seconds. The minute position advances only on a tick that ends the last second of a minute, and wraps from 63 to 0.
- R7: While `stop` is high, no tick is produced and the second/minute position is held. After `stop` falls, the next second is counted in full from zero.
- R8: With `ctrl[6]`=1, `pin_pull_low` toggles once every 2^FT_W enables (every 32 by default, giving 512 Hz). This is unaffected by the trim setting and by `stop`, and the first toggle comes 2^FT_W enables after reset.
- R9: With `ctrl[6]`=0, `pin_pull_low` is the inverse of `ctrl[7]`: a 0 pulls the pin low and a 1 releases it.
- R10: After reset, `sec_tick` is 0 and the cycle position is second 0 of minute 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle enable at the oscillator rate |
| stop | input | 1 | Holds the divider cleared; no ticks |
| ctrl | input | 8 | Magnitude [4:0], sign [5], test mode [6], static level [7] |
| sec_tick | output | 1 | One-cycle pulse per second |
| pin_pull_low | output | 1 | 1 = drive the open-drain pin low |

## Verification
The scoreboard predicts the length of every second in enables across whole minutes. It therefore catches a design that corrects the wrong second in a minute, uses magnitude instead of twice the magnitude, or still corrects minutes 62 and 63. It also catches a design that swaps the 256-enable shortening with the 128-enable stretch, or that counts idle cycles when enables have gaps.

A run through 65 minutes at full magnitude shows whether the minute position wraps to 0 and correction starts again. A stop pulse in the middle of a second shows whether a design emits ticks while stopped or loses its place in the minute. The test-mode run, with full trim and a stop pulse, would show a square wave that picks up the trim or freezes during stop.

// File: rtl/presc_pkg.sv
package presc_pkg;
    localparam int CTL_MAG_W    = 5;
    localparam int CTL_SIGN_BIT = 5;
    localparam int CTL_FT_BIT   = 6;
    localparam int CTL_LVL_BIT  = 7;

    typedef enum logic [1:0] {
        DV_HOLD    = 2'd0,
        DV_RUN     = 2'd1,
        DV_STRETCH = 2'd2
    } dv_state_e;
endpackage

// File: rtl/presc_div.sv
module presc_div
    import presc_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stop,
    input  logic corr,
    input  logic pos,
    output logic tick
);
    localparam int CNT_W = LO_W + HI_W;
    localparam int EXT_W = LO_W - 1;
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_MAX - CNT_W'(1 << LO_W);
    localparam logic [EXT_W-1:0] EXT_LAST  = '1;

    dv_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [EXT_W-1:0] ext_q, ext_d;
    logic             tick_d, tick_q;
    logic [CNT_W-1:0] last;

    assign last = (corr && pos) ? CNT_SHORT : CNT_MAX;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ext_d   = ext_q;
        tick_d  = 1'b0;
        if (stop) begin
            state_d = DV_HOLD;
            cnt_d   = '0;
            ext_d   = '0;
        end else if (en) begin
            unique case (state_q)
                DV_RUN, DV_HOLD: begin
                    state_d = DV_RUN;
                    if (cnt_q == last) begin
                        if (corr && !pos) begin
                            state_d = DV_STRETCH;
                            ext_d   = '0;
                        end else begin
                            tick_d = 1'b1;
                            cnt_d  = '0;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                DV_STRETCH: begin
                    if (ext_q == EXT_LAST) begin
                        tick_d  = 1'b1;
                        cnt_d   = '0;
                        state_d = DV_RUN;
                    end else begin
                        ext_d = ext_q + 1'b1;
                    end
                end
                default: state_d = DV_RUN;
            endcase
        end else if (state_q == DV_HOLD) begin
            state_d = DV_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DV_RUN;
            cnt_q   <= '0;
            ext_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ext_q   <= ext_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    assign tick = tick_q;

    p_tick_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> $past(en));
    p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !tick_q);
    p_tick_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
endmodule

// File: rtl/presc_pos.sv
module presc_pos
    import presc_pkg::*;
#(
    parameter int SEC_PER_MIN = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [CTL_MAG_W-1:0] mag,
    output logic                 corr
);
    localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
    localparam int MIN_W = CTL_MAG_W + 1;
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

    logic [SEC_W-1:0] sec_q;
    logic [MIN_W-1:0] min_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
        end else if (tick) begin
            if (sec_q == SEC_LAST) begin
                sec_q <= '0;
                min_q <= min_q + 1'b1;
            end else begin
                sec_q <= sec_q + 1'b1;
            end
        end
    end

    assign corr = (sec_q == '0) && (min_q < {mag, 1'b0});

    p_min_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(min_q));
    p_sec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q <= SEC_LAST);
endmodule

// File: rtl/presc_ft.sv
module presc_ft #(
    parameter int FT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sq
);
    logic [FT_W-1:0] cnt_q;
    logic            sq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sq_q  <= 1'b0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '1) sq_q <= ~sq_q;
        end
    end

    assign sq = sq_q;

    p_ft_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sq_q));
endmodule

// File: rtl/presc_top.sv
module presc_top
    import presc_pkg::*;
#(
    parameter int LO_W        = 8,
    parameter int HI_W        = 7,
    parameter int SEC_PER_MIN = 60,
    parameter int FT_W        = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       stop,
    input  logic [7:0] ctrl,
    output logic       sec_tick,
    output logic       pin_pull_low
);
    logic corr;
    logic ft_sq;

    presc_div #(.LO_W(LO_W), .HI_W(HI_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (osc_en),
        .stop (stop),
        .corr (corr),
        .pos  (ctrl[CTL_SIGN_BIT]),
        .tick (sec_tick)
    );

    presc_pos #(.SEC_PER_MIN(SEC_PER_MIN)) u_pos (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (sec_tick),
        .mag  (ctrl[CTL_MAG_W-1:0]),
        .corr (corr)
    );

    presc_ft #(.FT_W(FT_W)) u_ft (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (osc_en),
        .sq   (ft_sq)
    );

    assign pin_pull_low = ctrl[CTL_FT_BIT] ? ft_sq : ~ctrl[CTL_LVL_BIT];

    p_lvl_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CTL_FT_BIT] |-> (pin_pull_low != ctrl[CTL_LVL_BIT]));
endmodule

// File: tb/sim_presc_top.sv
module sim_presc_top;
    localparam int CLK_P = 10;
    localparam int LO_W  = 3;
    localparam int HI_W  = 2;
    localparam int SPM   = 4;
    localparam int FT_W  = 3;
    localparam int LEN_N = 1 << (LO_W + HI_W);
    localparam int LEN_P = LEN_N - (1 << LO_W);
    localparam int LEN_M = LEN_N + (1 << (LO_W - 1));

    logic       clk = 0;
    logic       rst_n = 0;
    logic       osc_en = 0;
    logic       stop = 0;
    logic [7:0] ctrl = 8'h00;
    logic       sec_tick, pin_pull_low;

    int n_run = 0, n_fail = 0;
    int cyc = 0;
    bit gaps = 0, sb_on = 0, ft_watch = 0;
    int ecnt = 0, fcnt = 0, stop_ticks = 0, ft_toggles = 0;
    logic pin_prev;
    int    exp_len[$];
    string exp_tag[$];

    presc_top #(.LO_W(LO_W), .HI_W(HI_W), .SEC_PER_MIN(SPM), .FT_W(FT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .ctrl(ctrl),
        .sec_tick(sec_tick), .pin_pull_low(pin_pull_low)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        cyc++;
        osc_en <= gaps ? ((cyc % 3) != 0) : 1'b1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            ecnt = 0; fcnt = 0; pin_prev = pin_pull_low;
        end else begin
            if (sec_tick) begin
                if (stop) stop_ticks++;
                if (sb_on) begin
                    if (exp_len.size() == 0) check(0, "R1 unexpected tick", ecnt, -1);
                    else begin
                        automatic int e = exp_len.pop_front();
                        automatic string t = exp_tag.pop_front();
                        check(ecnt == e, t, ecnt, e);
                    end
                end
                ecnt = 0;
            end
            if (stop) ecnt = 0;
            else if (osc_en) ecnt++;
            if (ft_watch) begin
                if (pin_pull_low != pin_prev) begin
                    ft_toggles++;
                    check(fcnt == (1 << FT_W), "R8 toggle spacing", fcnt, 1 << FT_W);
                    fcnt = 0;
                end
                if (osc_en) fcnt++;
            end
            pin_prev = pin_pull_low;
        end
    end

    task automatic do_reset(input logic [7:0] c);
        @(posedge clk); #1;
        rst_n = 0; ctrl = c;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic push_sec(input int m, input int s, input logic [7:0] c);
        if (s == 0 && m < 2 * int'(c[4:0])) begin
            exp_len.push_back(c[5] ? LEN_P : LEN_M);
            exp_tag.push_back(c[5] ? "R4 shortened second" : "R5 stretched second");
        end else begin
            exp_len.push_back(LEN_N);
            exp_tag.push_back(s == 0 ? "R3 uncorrected first second" : "R1 plain second");
        end
    endtask

    task automatic drain();
        while (exp_len.size() > 0) @(posedge clk);
    endtask

    task automatic run_phase(input logic [7:0] c, input int nmin, input bit g);
        gaps = g;
        do_reset(c);
        sb_on = 1;
        for (int m = 0; m < nmin; m++)
            for (int s = 0; s < SPM; s++) push_sec(m % 64, s, c);
        drain();
        @(negedge clk);
        sb_on = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", exp_len.size());
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset(8'h80);
        @(negedge clk);
        check(sec_tick == 0, "R10 tick low after reset", sec_tick, 0);
        check(pin_pull_low == 0, "R9 level 1 releases pin", pin_pull_low, 0);
        ctrl = 8'h00;
        @(negedge clk);
        check(pin_pull_low == 1, "R9 level 0 pulls pin low", pin_pull_low, 1);

        run_phase(8'h00, 2, 0);
        run_phase(8'h22, 6, 0);
        run_phase(8'h01, 3, 1);
        run_phase(8'h3F, 65, 0);

        // R7 stop holds position and clears the divider
        gaps = 0;
        do_reset(8'h01);
        sb_on = 1;
        push_sec(0, 0, 8'h01); push_sec(0, 1, 8'h01);
        drain();
        repeat (5) @(posedge clk);
        #1 stop = 1; stop_ticks = 0;
        repeat (3 * LEN_M) @(posedge clk);
        #1 stop = 0;
        check(stop_ticks == 0, "R7 no tick while stopped", stop_ticks, 0);
        push_sec(0, 2, 8'h01); push_sec(0, 3, 8'h01);
        push_sec(1, 0, 8'h01); push_sec(1, 1, 8'h01);
        push_sec(2, 0, 8'h01);
        drain();
        @(negedge clk);
        sb_on = 0;

        // R8 test square wave with full trim, gaps and a stop pulse
        gaps = 1;
        ft_toggles = 0;
        ft_watch = 1;
        do_reset(8'h7F);
        repeat (200) @(posedge clk);
        #1 stop = 1;
        repeat (40) @(posedge clk);
        #1 stop = 0;
        repeat (200) @(posedge clk);
        @(negedge clk);
        ft_watch = 0;
        check(ft_toggles > 20, "R8 square wave present", ft_toggles, 21);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule